// File: doc/BRIEF.md
# FSK Carrier Detect Qualifier

This block turns a per-sample "in-band energy present" flag, produced by an FSK band-pass filter and level detector upstream, into an active-low carrier-detect output for a caller-identification receiver. Activation is deliberately slow and statistical. The flag must be present in at least three quarters of the samples over a sliding window. The window is built from a ring of equal segments, so it advances one segment at a time. Once carrier is declared, the output rides through short dropouts. It releases only after the flag has been absent for a full hold interval without a break.

The defaults assume a 3.579545 MHz sample clock. The window is 8 segments of 1790 samples (about 4 ms). That keeps activation well inside a 25 ms budget from the start of valid FSK. The hold interval is 28636 samples (about 8 ms). A gate output tells the serial data interface when demodulated bits may pass. A low FSK enable or an active power-down holds the whole block inactive and clears its counters. Speech and alert tones therefore cannot assert carrier detect while FSK is not expected.

Top module: `cdq_carrier_qual`

## Requirements
- R1: During and after reset, `cd_n` is 1 and `data_gate` is 0.
- R2: With the block enabled, `cd_n` falls right after the clock edge that samples the last flag of a completed window of `SEG_LEN*NSEG` samples, if at least 75% of them had `nrg`=1. With the bench parameters (8x4), 32 consecutive ones give `cd_n`=0 after the 32nd edge and not after the 31st. Exactly 24 of 32 (pattern 1110 repeated) also activates.
- R3: A window with 23 of 32 flags set does not activate, and nor does any later window that contains fewer hits.
- R4: The window slides by whole segments: the oldest segment count drops out at each segment boundary. A window that misses at edge 32 but qualifies at edge 40 activates after edge 40.
- R5: While active, a run of fewer than `HOLD_CYC` consecutive samples with `nrg`=0 leaves `cd_n` at 0.
- R6: While active, `cd_n` returns to 1 right after the edge that samples the `HOLD_CYC`-th consecutive `nrg`=0.
- R7: Any sample with `nrg`=1 while active restarts the absence count from zero.
- R8: An edge sampling `fsk_en`=0 forces `cd_n` to 1 and clears all counters. While `fsk_en` stays 0, no flag pattern asserts carrier. After re-enabling, a full fresh window is needed.
- R9: An edge sampling `pwdn`=1 has the same effect as R8.
- R10: `data_gate` is always the complement of `cd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwdn | input | 1 | Power-down, high forces inactive |
| fsk_en | input | 1 | FSK enable, low forces inactive |
| nrg | input | 1 | Per-sample in-band energy present flag |
| cd_n | output | 1 | Carrier detect, active low |
| data_gate | output | 1 | High when the data interface may pass demodulated bits |

## Verification
The assertions assume that `nrg`, `fsk_en` and `pwdn` change only between clock edges and carry no X once reset is released. They also assume that the segment, window and hold counters start from reset in a cleared state. The bench drives every input one time unit after a rising edge and holds it steady across the next edge. It releases reset the same way. Each scenario starts from a fresh reset, so no property sees a partly filled window from an earlier test.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
  localparam int unsigned QUAL_NUM = 3;
  localparam int unsigned QUAL_DEN = 4;

  // Qualification test: hits / total >= QUAL_NUM / QUAL_DEN
  function automatic logic qual_met(input int unsigned hits, input int unsigned total);
    return (hits * QUAL_DEN) >= (total * QUAL_NUM);
  endfunction

  // Next fill level of a saturating segment count
  function automatic int unsigned fill_step(input int unsigned fill, input int unsigned limit);
    return (fill >= limit) ? limit : fill + 1;
  endfunction

  // Ring pointer advance with wrap
  function automatic int unsigned ptr_step(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/cdq_seg_counter.sv
module cdq_seg_counter #(
  parameter int unsigned SEG_LEN = 1790,
  localparam int unsigned SEG_W = $clog2(SEG_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             nrg,
  output logic             seg_end,
  output logic [SEG_W-1:0] seg_total
);
  logic [SEG_W-1:0] pos_q;
  logic [SEG_W-1:0] hits_q;

  assign seg_end   = !clr && (pos_q == SEG_W'(SEG_LEN - 1));
  assign seg_total = hits_q + SEG_W'(nrg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      hits_q <= '0;
    end else if (clr || seg_end) begin
      pos_q  <= '0;
      hits_q <= '0;
    end else begin
      pos_q  <= pos_q + 1'b1;
      hits_q <= seg_total;
    end
  end
endmodule

// File: rtl/cdq_window_sum.sv
module cdq_window_sum
  import cdq_pkg::*;
#(
  parameter int unsigned SEG_LEN = 1790,
  parameter int unsigned NSEG    = 8,
  localparam int unsigned SEG_W  = $clog2(SEG_LEN + 1),
  localparam int unsigned SUM_W  = $clog2(SEG_LEN * NSEG + 1),
  localparam int unsigned FILL_W = $clog2(NSEG + 1),
  localparam int unsigned PTR_W  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             seg_end,
  input  logic [SEG_W-1:0] seg_total,
  output logic             win_ok
);
  localparam int unsigned WIN_LEN = SEG_LEN * NSEG;

  logic [SEG_W-1:0]  ring_q [NSEG];
  logic [PTR_W-1:0]  ptr_q;
  logic [FILL_W-1:0] fill_q;
  logic [SUM_W-1:0]  sum_q;

  logic [SUM_W-1:0]  sum_next;
  logic [FILL_W-1:0] fill_next;
  logic [PTR_W-1:0]  ptr_next;

  always_comb begin
    sum_next  = sum_q - SUM_W'(ring_q[ptr_q]) + SUM_W'(seg_total);
    fill_next = FILL_W'(fill_step(int'(fill_q), NSEG));
    ptr_next  = PTR_W'(ptr_step(int'(ptr_q), NSEG));
  end

  assign win_ok = seg_end && (fill_next == FILL_W'(NSEG)) && qual_met(int'(sum_next), WIN_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fill_q <= '0;
      sum_q  <= '0;
    end else if (clr) begin
      ptr_q  <= '0;
      fill_q <= '0;
      sum_q  <= '0;
    end else if (seg_end) begin
      ptr_q  <= ptr_next;
      fill_q <= fill_next;
      sum_q  <= sum_next;
    end
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ring_q[g] <= '0;
      else if (clr)
        ring_q[g] <= '0;
      else if (seg_end && ptr_q == PTR_W'(g))
        ring_q[g] <= seg_total;
    end
  end
endmodule

// File: rtl/cdq_hold_timer.sv
module cdq_hold_timer #(
  parameter int unsigned HOLD_CYC = 28636,
  localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic nrg,
  output logic hold_expire
);
  logic [HOLD_W-1:0] absent_q;

  assign hold_expire = run && !nrg && (absent_q == HOLD_W'(HOLD_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      absent_q <= '0;
    else if (!run || nrg || hold_expire)
      absent_q <= '0;
    else
      absent_q <= absent_q + 1'b1;
  end
endmodule

// File: rtl/cdq_carrier_qual.sv
module cdq_carrier_qual #(
  parameter int unsigned SEG_LEN  = 1790,
  parameter int unsigned NSEG     = 8,
  parameter int unsigned HOLD_CYC = 28636,
  localparam int unsigned SEG_W   = $clog2(SEG_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn,
  input  logic fsk_en,
  input  logic nrg,
  output logic cd_n,
  output logic data_gate
);
  logic             active_q;
  logic             idle;
  logic             win_clr;
  logic             seg_end;
  logic [SEG_W-1:0] seg_total;
  logic             win_ok;
  logic             hold_run;
  logic             hold_expire;

  assign idle     = pwdn || !fsk_en;
  assign win_clr  = idle || active_q;
  assign hold_run = active_q && !idle;

  cdq_seg_counter #(.SEG_LEN(SEG_LEN)) u_seg (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .nrg(nrg),
    .seg_end(seg_end), .seg_total(seg_total)
  );

  cdq_window_sum #(.SEG_LEN(SEG_LEN), .NSEG(NSEG)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .seg_end(seg_end),
    .seg_total(seg_total), .win_ok(win_ok)
  );

  cdq_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(hold_run), .nrg(nrg),
    .hold_expire(hold_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      active_q <= 1'b0;
    else if (idle)
      active_q <= 1'b0;
    else if (!active_q && win_ok)
      active_q <= 1'b1;
    else if (active_q && hold_expire)
      active_q <= 1'b0;
  end

  assign cd_n      = !active_q;
  assign data_gate = active_q;
endmodule

// File: rtl/cdq_checker.sv
module cdq_checker #(
  parameter int unsigned HOLD_CYC = 28636
) (
  input logic clk,
  input logic rst_n,
  input logic idle,
  input logic nrg,
  input logic win_ok,
  input logic hold_expire,
  input logic cd_n
);
  logic [31:0] absent_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      absent_run <= '0;
    else if (cd_n || idle || nrg)
      absent_run <= '0;
    else
      absent_run <= absent_run + 1;
  end

  p_activate_needs_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cd_n) |-> $past(win_ok));

  p_idle_forces_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> cd_n);

  p_energy_keeps_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_n && nrg && !idle) |=> !cd_n);

  p_release_needs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cd_n) && !$past(idle)) |-> $past(hold_expire));

  p_hold_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (absent_run >= HOLD_CYC) |-> cd_n);
endmodule

bind cdq_carrier_qual cdq_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .nrg(nrg), .win_ok(win_ok),
  .hold_expire(hold_expire), .cd_n(cd_n)
);

// File: tb/sim_cdq_carrier_qual.sv
`timescale 1ns/1ps
module sim_cdq_carrier_qual;
  localparam int unsigned SEG_LEN = 8;
  localparam int unsigned NSEG    = 4;
  localparam int unsigned HOLD    = 20;
  localparam int unsigned WIN     = SEG_LEN * NSEG;

  logic clk = 1'b0;
  logic rst_n, pwdn, fsk_en, nrg;
  logic cd_n, data_gate;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = !clk;

  cdq_carrier_qual #(.SEG_LEN(SEG_LEN), .NSEG(NSEG), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .pwdn(pwdn), .fsk_en(fsk_en), .nrg(nrg),
    .cd_n(cd_n), .data_gate(data_gate)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
    total++;
    if (data_gate !== !got) begin
      bad++;
      $display("FAIL R10: data_gate %b expected %b at %0t", data_gate, !got, $time);
    end
  endtask

  task automatic tick(input logic v);
    nrg = v;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwdn = 1'b0; fsk_en = 1'b1; nrg = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 during reset", cd_n, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic activate();
    for (int i = 1; i <= WIN; i++) tick(1'b1);
    chk("R2 activate helper", cd_n, 1'b0);
  endtask

  task automatic t_reset_state();
    do_reset();
    tick(1'b0);
    chk("R1 after reset", cd_n, 1'b1);
  endtask

  task automatic t_full_window();
    do_reset();
    for (int i = 1; i < WIN; i++) tick(1'b1);
    chk("R2 edge 31", cd_n, 1'b1);
    tick(1'b1);
    chk("R2 edge 32", cd_n, 1'b0);
  endtask

  task automatic t_exact_threshold();
    do_reset();
    for (int i = 0; i < WIN; i++) tick((i % 4) != 3);
    chk("R2 24 of 32", cd_n, 1'b0);
  endtask

  task automatic t_below_threshold();
    do_reset();
    for (int i = 0; i < SEG_LEN; i++) tick(i < 5);
    for (int s = 1; s < NSEG; s++)
      for (int i = 0; i < SEG_LEN; i++) tick(i < 6);
    chk("R3 23 of 32", cd_n, 1'b1);
    for (int i = 0; i < WIN; i++) tick(1'b0);
    chk("R3 later windows", cd_n, 1'b1);
  endtask

  task automatic t_sliding();
    do_reset();
    for (int i = 0; i < SEG_LEN; i++) tick(1'b0);
    for (int i = 0; i < SEG_LEN; i++) tick(i < 4);
    for (int i = 0; i < 2 * SEG_LEN; i++) tick(1'b1);
    chk("R4 edge 32 miss", cd_n, 1'b1);
    for (int i = 1; i < SEG_LEN; i++) tick(1'b1);
    chk("R4 edge 39", cd_n, 1'b1);
    tick(1'b1);
    chk("R4 edge 40", cd_n, 1'b0);
  endtask

  task automatic t_hold_release();
    do_reset();
    activate();
    for (int i = 1; i < HOLD; i++) tick(1'b0);
    chk("R5 short dropout", cd_n, 1'b0);
    tick(1'b1);
    chk("R5 energy back", cd_n, 1'b0);
    for (int i = 1; i < HOLD; i++) tick(1'b0);
    chk("R6 one before hold", cd_n, 1'b0);
    tick(1'b0);
    chk("R6 hold expired", cd_n, 1'b1);
  endtask

  task automatic t_hold_restart();
    do_reset();
    activate();
    for (int i = 0; i < 15; i++) tick(1'b0);
    tick(1'b1);
    for (int i = 1; i < HOLD; i++) tick(1'b0);
    chk("R7 restarted count", cd_n, 1'b0);
    tick(1'b0);
    chk("R7 release after restart", cd_n, 1'b1);
  endtask

  task automatic t_disable(input bit use_pwdn, input string req);
    do_reset();
    activate();
    if (use_pwdn) pwdn = 1'b1; else fsk_en = 1'b0;
    tick(1'b1);
    chk({req, " forced off"}, cd_n, 1'b1);
    for (int i = 0; i < 2 * WIN; i++) tick(1'b1);
    chk({req, " held off"}, cd_n, 1'b1);
    pwdn = 1'b0; fsk_en = 1'b1;
    for (int i = 0; i < 20; i++) tick(1'b1);
    if (use_pwdn) pwdn = 1'b1; else fsk_en = 1'b0;
    tick(1'b1);
    pwdn = 1'b0; fsk_en = 1'b1;
    for (int i = 1; i < WIN; i++) tick(1'b1);
    chk({req, " counters cleared"}, cd_n, 1'b1);
    tick(1'b1);
    chk({req, " fresh window"}, cd_n, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_full_window();
    t_exact_threshold();
    t_below_threshold();
    t_sliding();
    t_hold_release();
    t_hold_restart();
    t_disable(1'b0, "R8");
    t_disable(1'b1, "R9");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule